// File: doc/BRIEF.md
# ADC Serial Power-Mode Controller

This block sits on the host side of a dual-channel 12-bit serial converter. It drives the chip-select and serial-clock lines, and it returns both channels of each conversion as parallel 12-bit words. The converter changes power mode only through the way a frame is framed. If chip select goes high early, inside a fixed window of falling clock edges, the conversion is aborted and the converter drops into a lower power state. Doing the same in the next frame as well takes it from partial power-down to full power-down. To leave either power-down state, the host runs a dummy frame that is clocked to the end, discards its data, and then waits for a power-up time that depends on how deep the converter had gone.

The host issues one of four commands per request: convert, partial power-down, full power-down, or wake. The controller keeps its own model of the converter's power state. From that model it decides which frames to run: aborted frames, dummy frames, waits and real conversions. It holds `busy` high until the whole sequence has finished. A convert request made while the converter is powered down first performs the wake sequence. Only after that does it run the real conversion.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `cs_n` = 1, `sclk` = 1, `busy` = 0, `res_valid` = 0, and `pwr_state` = 0 (active).
- R2: `cmd` = 0 (convert), issued while `pwr_state` = 0, runs exactly one frame of FRAME_BITS falling `sclk` edges with `cs_n` low throughout. Each channel line is sampled at the falling edges numbered LEAD+1 to LEAD+12, and the first sampled bit becomes bit 11 (MSB first).
- R3: `sclk` is high whenever `cs_n` is high. Each low phase of `sclk` lasts DIV system-clock cycles.
- R4: `cmd` = 1 (partial power-down), issued while active, runs one frame in which `cs_n` rises after falling edge ABORT_EDGE and before the next falling edge. After it, `pwr_state` = 1.
- R5: `cmd` = 2 (full power-down) runs two aborted frames from the active state, or one aborted frame from partial power-down. After it, `pwr_state` = 2. An aborted frame taken from the active state always leads to state 1 first.
- R6: A power-down command that would not make the power state deeper runs no frame and leaves `pwr_state` unchanged. This covers partial power-down while in state 1 or 2, and full power-down while in state 2. A wake command (`cmd` = 3) while active also runs no frame and changes nothing.
- R7: Wake from power-down runs one full dummy frame that produces no `res_valid`. After that frame, `pwr_state` = 3 for exactly TPU_PARTIAL cycles (from state 1) or TPU_FULL cycles (from state 2), and then becomes 0.
- R8: Convert while powered down runs the wake sequence of R7 and then one real conversion frame. `res_valid` pulses exactly once, for one cycle, while `pwr_state` = 0, and carries the data of the real frame.
- R9: `busy` is high from the cycle after a command is accepted until its whole sequence has ended. `cmd_ready` is the inverse of `busy`. Commands presented while busy are ignored. `cs_n` is high whenever the controller is idle.
- R10: `pwr_state` is encoded as 0 = active, 1 = partial power-down, 2 = full power-down, 3 = powering up. `busy` is high whenever `pwr_state` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | 0 convert, 1 partial power-down, 2 full power-down, 3 wake |
| cmd_ready | output | 1 | High when a command can be accepted |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata_a | input | 1 | Channel A serial data |
| sdata_b | input | 1 | Channel B serial data |
| res_valid | output | 1 | One-cycle pulse when a result pair is ready |
| res_a | output | RES_W | Channel A result |
| res_b | output | RES_W | Channel B result |
| busy | output | 1 | Command sequence in progress |
| pwr_state | output | 2 | Modelled converter power state |

## Verification
The assertions check the following on every cycle:
- `sclk` rests high whenever chip select is high.
- Chip select rises on the abort edge in aborted frames and on the last edge in full frames.
- `res_valid` appears only at the end of a frame, with the converter modelled as active.
- Leaving the active state always passes through partial power-down.
- The powering-up state only occurs while busy.

Only the bench's command sequences can show the rest. That includes the number of frames each command produces in each power state, the MSB-first order of the captured data, and the exact length of the power-up waits. It also includes which redundant commands run no frame at all, and which requests are dropped while busy.

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl #(
  parameter int DIV         = 4,
  parameter int FRAME_BITS  = 16,
  parameter int ABORT_EDGE  = 4,
  parameter int LEAD        = 2,
  parameter int RES_W       = 12,
  parameter int TPU_PARTIAL = 64,
  parameter int TPU_FULL    = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd,
  output logic             cmd_ready,
  output logic             cs_n,
  output logic             sclk,
  input  logic             sdata_a,
  input  logic             sdata_b,
  output logic             res_valid,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             busy,
  output logic [1:0]       pwr_state
);
  localparam int DCW = $clog2(DIV + 1);
  localparam int EW  = $clog2(FRAME_BITS + 1);
  localparam int TW  = $clog2(TPU_FULL + TPU_PARTIAL + DIV + 1);

  localparam logic [1:0] C_CONV = 2'd0, C_PDP = 2'd1, C_PDF = 2'd2, C_WAKE = 2'd3;
  localparam logic [1:0] P_ACT = 2'd0, P_PART = 2'd1, P_FULL = 2'd2, P_WAKE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_WAIT} st_t;
  typedef enum logic [1:0] {K_CONV, K_ABORT, K_DUMMY} kind_t;

  st_t              st;
  kind_t            kind, nk;
  logic             more, conv_after, from_full, next_frame;
  logic             go, nmore, nconv;
  logic [DCW-1:0]   div_cnt;
  logic [EW-1:0]    edge_cnt;
  logic [TW-1:0]    wait_cnt;
  logic [RES_W-1:0] sh_a, sh_b;

  wire tick      = (st == S_FRAME) && (div_cnt == DCW'(DIV - 1));
  wire fall      = tick && sclk;
  wire rise      = tick && !sclk;
  wire [EW-1:0] last_edge = (kind == K_ABORT) ? EW'(ABORT_EDGE) : EW'(FRAME_BITS);
  wire frame_end = rise && (edge_cnt == last_edge);
  wire cap       = fall && (kind == K_CONV) && (edge_cnt >= EW'(LEAD)) &&
                   (edge_cnt < EW'(LEAD + RES_W));

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;

  always_comb begin
    go = 1'b0; nk = K_CONV; nmore = 1'b0; nconv = 1'b0;
    case (cmd)
      C_CONV: begin
        go = 1'b1;
        if (pwr_state != P_ACT) begin nk = K_DUMMY; nconv = 1'b1; end
      end
      C_PDP:  if (pwr_state == P_ACT) begin go = 1'b1; nk = K_ABORT; end
      C_PDF: begin
        if (pwr_state == P_ACT) begin go = 1'b1; nk = K_ABORT; nmore = 1'b1; end
        else if (pwr_state == P_PART) begin go = 1'b1; nk = K_ABORT; end
      end
      default: if (pwr_state != P_ACT) begin go = 1'b1; nk = K_DUMMY; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_CONV; more <= 1'b0; conv_after <= 1'b0;
      from_full <= 1'b0; next_frame <= 1'b0; div_cnt <= '0; edge_cnt <= '0;
      wait_cnt <= '0; sh_a <= '0; sh_b <= '0; res_a <= '0; res_b <= '0;
      res_valid <= 1'b0; cs_n <= 1'b1; sclk <= 1'b1; pwr_state <= P_ACT;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid && go) begin
          kind <= nk; more <= nmore; conv_after <= nconv;
          from_full <= (pwr_state == P_FULL);
          st <= S_FRAME; cs_n <= 1'b0; div_cnt <= '0; edge_cnt <= '0;
        end
        S_FRAME: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (fall) begin
            sclk <= 1'b0;
            edge_cnt <= edge_cnt + 1'b1;
            if (cap) begin
              sh_a <= {sh_a[RES_W-2:0], sdata_a};
              sh_b <= {sh_b[RES_W-2:0], sdata_b};
            end
          end
          if (rise) sclk <= 1'b1;
          if (frame_end) begin
            cs_n <= 1'b1;
            st   <= S_WAIT;
            case (kind)
              K_CONV: begin
                res_a <= sh_a; res_b <= sh_b; res_valid <= 1'b1;
                wait_cnt <= TW'(DIV); next_frame <= 1'b0;
              end
              K_ABORT: begin
                pwr_state  <= (pwr_state == P_ACT) ? P_PART : P_FULL;
                wait_cnt   <= TW'(DIV);
                next_frame <= more;
                more       <= 1'b0;
              end
              default: begin
                pwr_state  <= P_WAKE;
                wait_cnt   <= from_full ? TW'(TPU_FULL) : TW'(TPU_PARTIAL);
                next_frame <= conv_after;
              end
            endcase
          end
        end
        default: begin
          if (wait_cnt <= TW'(1)) begin
            if (pwr_state == P_WAKE) pwr_state <= P_ACT;
            if (next_frame) begin
              if (kind == K_DUMMY) kind <= K_CONV;
              next_frame <= 1'b0;
              st <= S_FRAME; cs_n <= 1'b0; div_cnt <= '0; edge_cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_abort_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && kind == K_ABORT) |-> edge_cnt == EW'(ABORT_EDGE));
  assert_full_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && kind != K_ABORT) |-> edge_cnt == EW'(FRAME_BITS));
  assert_valid_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($rose(cs_n) && pwr_state == P_ACT));
  assert_pd_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == P_ACT && pwr_state != P_ACT) |-> pwr_state == P_PART);
  assert_waking_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == P_WAKE) |-> (busy && cs_n));
  assert_idle_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

// File: tb/tb_adc_pwr_ctrl.sv
module tb_adc_pwr_ctrl;
  localparam int DIV = 2, FB = 16, AE = 4, TPP = 20, TPF = 200;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic sdata_a = 1'b0, sdata_b = 1'b0;
  logic cmd_ready, cs_n, sclk, res_valid, busy;
  logic [11:0] res_a, res_b;
  logic [1:0] pwr_state;

  always #2 clk = ~clk;

  adc_pwr_ctrl #(.DIV(DIV), .FRAME_BITS(FB), .ABORT_EDGE(AE), .LEAD(2), .RES_W(12),
                 .TPU_PARTIAL(TPP), .TPU_FULL(TPF)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_ready(cmd_ready),
    .cs_n(cs_n), .sclk(sclk), .sdata_a(sdata_a), .sdata_b(sdata_b),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b), .busy(busy), .pwr_state(pwr_state));

  int tests = 0, fails = 0;
  int ecnt = 0, frames = 0, last_edges = 0, vcnt = 0, wcnt = 0, low_run = 0, last_low = 0;
  logic [11:0] pa = '0, pb = '0, got_a = '0, got_b = '0;

  function automatic logic bitfor(input logic [11:0] w, input int n);
    if (n >= 3 && n <= 14) return w[14-n];
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin ecnt = 0; sdata_a = bitfor(pa, 1); sdata_b = bitfor(pb, 1); end
  always @(negedge sclk) if (!cs_n) begin
    ecnt++;
    sdata_a = bitfor(pa, ecnt + 1);
    sdata_b = bitfor(pb, ecnt + 1);
  end
  always @(posedge cs_n) begin frames++; last_edges = ecnt; end
  always @(negedge clk) if (rst_n) begin
    if (res_valid) begin vcnt++; got_a = res_a; got_b = res_b; end
    if (pwr_state == 2'd3) wcnt++;
    if (!sclk) low_run++;
    else if (low_run != 0) begin last_low = low_run; low_run = 0; end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    cmd = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // fields: cmd[11:10] frames[9:8] last-frame edges[7:3] pwr after[2:1] valid[0]
  localparam logic [11:0] VEC [14] = '{
    {2'd0, 2'd1, 5'd16, 2'd0, 1'b1},  // R2 convert
    {2'd1, 2'd1, 5'd4,  2'd1, 1'b0},  // R4 partial
    {2'd1, 2'd0, 5'd0,  2'd1, 1'b0},  // R6 redundant
    {2'd3, 2'd1, 5'd16, 2'd0, 1'b0},  // R7 wake partial
    {2'd2, 2'd2, 5'd4,  2'd2, 1'b0},  // R5 full from active
    {2'd0, 2'd2, 5'd16, 2'd0, 1'b1},  // R8 convert from full
    {2'd1, 2'd1, 5'd4,  2'd1, 1'b0},  // R4
    {2'd2, 2'd1, 5'd4,  2'd2, 1'b0},  // R5 full from partial
    {2'd2, 2'd0, 5'd0,  2'd2, 1'b0},  // R6
    {2'd3, 2'd1, 5'd16, 2'd0, 1'b0},  // R7 wake full
    {2'd3, 2'd0, 5'd0,  2'd0, 1'b0},  // R6 wake while active
    {2'd2, 2'd2, 5'd4,  2'd2, 1'b0},  // R5
    {2'd1, 2'd0, 5'd0,  2'd2, 1'b0},  // R6 partial while full
    {2'd0, 2'd2, 5'd16, 2'd0, 1'b1}   // R8
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    int f0, v0, w0, expw;
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !busy && !res_valid && pwr_state == 2'd0, "R1 reset", {cs_n, sclk, busy, pwr_state}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && sclk && !busy && cmd_ready && pwr_state == 2'd0, "R1 after reset", {cs_n, sclk, busy}, 3'b110);

    prev = 2'd0;
    for (int i = 0; i < 14; i++) begin
      pa = 12'hA5C ^ 12'(i * 37); pb = ~pa ^ 12'(i);
      f0 = frames; v0 = vcnt; w0 = wcnt;
      expw = ((VEC[i][11:10] == 2'd0 || VEC[i][11:10] == 2'd3) && prev != 2'd0) ?
             ((prev == 2'd2) ? TPF : TPP) : 0;
      issue(VEC[i][11:10]);
      @(negedge clk);
      check(frames - f0 == int'(VEC[i][9:8]), "R4 R5 R6 frame count", frames - f0, int'(VEC[i][9:8]));
      if (VEC[i][9:8] != 0)
        check(last_edges == int'(VEC[i][7:3]), "R2 R4 falling edges in frame", last_edges, int'(VEC[i][7:3]));
      check(pwr_state == VEC[i][2:1], "R10 power state", pwr_state, VEC[i][2:1]);
      check(vcnt - v0 == int'(VEC[i][0]), "R7 R8 valid pulses", vcnt - v0, int'(VEC[i][0]));
      if (VEC[i][0]) begin
        check(got_a == pa, "R2 channel A MSB first", got_a, pa);
        check(got_b == pb, "R2 channel B MSB first", got_b, pb);
      end
      check(wcnt - w0 == expw, "R7 power-up wait", wcnt - w0, expw);
      prev = VEC[i][2:1];
    end

    check(last_low == DIV, "R3 sclk low phase", last_low, DIV);

    // R9: request while busy is dropped
    f0 = frames;
    @(negedge clk); cmd = 2'd0; cmd_valid = 1'b1;
    @(negedge clk); cmd = 2'd1;
    check(busy && !cmd_ready, "R9 busy after accept", {busy, cmd_ready}, 2'b10);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(frames - f0 == 1 && pwr_state == 2'd0, "R9 ignored while busy", frames - f0, 1);

    // R1: reset in the middle of a frame
    @(negedge clk); cmd = 2'd0; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (7) @(negedge clk);
    check(!cs_n, "R2 cs low mid frame", cs_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_n && sclk && !busy && pwr_state == 2'd0, "R1 reset mid frame", {cs_n, sclk, busy}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule